// File: doc/BRIEF.md
# Signal Detect Qualifier

This block turns a raw line-amplitude comparison bit into a qualified signal-detect flag. The comparator result arrives as a single bit from a clock domain that is not assumed to be related. It passes through a synchronizer and then drives a settling counter. The counter gives the receive equalizer time to adapt before the rest of the receiver trusts the line.

The flag is deliberately asymmetric. It rises only after the synchronized level has stayed high for a full settling interval. It falls as soon as the synchronized level drops. A loopback control overrides the flag to high while the settling timer keeps tracking the real line.

The settling interval is a parameter counted in reference-clock cycles. The default is 2,000,000 cycles, which is 80 ms at 25 MHz. A small value may be used in simulation.

Top module: `sigdet_qualifier`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the synchronizer, the settling counter and the output-enable flag are cleared. `sig_det` is low after any edge at which `rst_n` was sampled low, whatever `loopback` is.
- R2: `level_raw` passes through `SYNC_STAGES` (default 2) flip-flops before it is used. A change sampled at edge k is therefore seen by the timer logic after edge k+1.
- R3: When `level_raw` is sampled high at consecutive edges starting at edge k, `sig_det` rises right after edge k+1+`SETTLE_CYCLES` and not earlier.
- R4: Once `sig_det` is high through line qualification, it stays high for as long as `level_raw` continues to be sampled high.
- R5: When `level_raw` is first sampled low at edge k, `sig_det` (with `loopback` low) is low right after edge k+1. That is the first edge at which the synchronized level is low.
- R6: If the synchronized level drops before the interval completes, the count restarts from zero. A later rise again needs a full `SETTLE_CYCLES` interval.
- R7: While `loopback` is high and reset was not sampled at the last edge, `sig_det` is high in the same cycle, independently of the line level.
- R8: The settling timer keeps running while `loopback` is high. When `loopback` is released, `sig_det` immediately shows the true line qualification state.
- R9: The settling counter saturates at `SETTLE_CYCLES` and never wraps, however long the level stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| level_raw | input | 1 | Comparator result: line amplitude above threshold |
| loopback | input | 1 | High selects loopback, forcing the flag high |
| sig_det | output | 1 | Qualified signal-detect flag |

## Verification
A settling counter that is off by one moves the rising edge of `sig_det` by one cycle. That is visible on the very first full-length pulse. A counter that does not clear on a short drop shows up as an early rise on the next pulse. A counter that wraps shows up as a spurious drop after 2^width cycles of steady signal. The bench sweeps every pulse length around the interval boundary with several gap lengths and with loopback on and off. It compares `sig_det` every cycle, so any wrong counter or synchronizer state shows up at the port within one interval plus two cycles.

// File: rtl/sdq_pkg.sv
// Package: shared types and helpers for the signal detect qualifier.
// Assumes: nothing beyond IEEE 1800-2017 elaboration-time functions.
package sdq_pkg;

    // Which condition currently holds the detect flag high.
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_LINE = 2'd1,
        SRC_LOOP = 2'd2
    } sdq_src_e;

    // Width of a counter that must hold values 0..limit.
    function automatic int unsigned cnt_width(input int unsigned limit);
        int unsigned w;
        w = 1;
        while ((64'd1 << w) <= 64'(limit)) w++;
        return w;
    endfunction

endpackage

// File: rtl/sdq_sync.sv
// Module: multi-stage synchronizer for a single level bit.
// Assumes: the input is a slow level (held for many cycles), so only
// metastability matters and no pulse stretching is needed.
module sdq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        genvar g;
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Purpose: capture the asynchronous input into the first flop.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_i;
                end
            end else begin : g_rest
                // Purpose: pass the sample down the chain one stage per edge.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sdq_settle_timer.sv
// Module: settling timer. It counts cycles of continuous high synchronized
// level, saturates at LIMIT and clears at once when the level drops.
// Assumes: LIMIT >= 1; level_i is already synchronous to clk.
module sdq_settle_timer #(
    parameter int unsigned LIMIT = 2_000_000,
    parameter int unsigned CW    = sdq_pkg::cnt_width(LIMIT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          level_i,
    output logic [CW-1:0] cnt_o,
    output logic          done_o
);
    localparam logic [CW-1:0] LIMIT_V = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Purpose: advance while the level is high, hold at LIMIT, clear on a drop.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!level_i)       cnt_q <= '0;
        else if (cnt_q != LIMIT_V) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o  = cnt_q;
    assign done_o = (cnt_q == LIMIT_V);
endmodule

// File: rtl/sdq_out_sel.sv
// Module: output selector. It combines line qualification and loopback
// into the detect flag and reports which source holds it.
// Assumes: line_ok_i already includes the current synchronized level.
module sdq_out_sel
    import sdq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     line_ok_i,
    input  logic     loop_i,
    output logic     det_o,
    output sdq_src_e src_o
);
    logic live_q;

    // Purpose: record that reset was released at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // Purpose: choose the source that holds the flag, loopback first.
    always_comb begin
        if (!live_q)        src_o = SRC_NONE;
        else if (loop_i)    src_o = SRC_LOOP;
        else if (line_ok_i) src_o = SRC_LINE;
        else                src_o = SRC_NONE;
    end

    assign det_o = (src_o != SRC_NONE);
endmodule

// File: rtl/sigdet_qualifier.sv
// Module: top of the signal detect qualifier. Synchronizer, settling timer
// and output selector in a chain.
// Assumes: SETTLE_CYCLES >= 1, SYNC_STAGES >= 2, synchronous active-low reset.
module sigdet_qualifier #(
    parameter int unsigned SETTLE_CYCLES = 2_000_000,
    parameter int unsigned SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_raw,
    input  logic loopback,
    output logic sig_det
);
    import sdq_pkg::*;

    localparam int unsigned CW = cnt_width(SETTLE_CYCLES);

    logic          level_s;
    logic [CW-1:0] settle_cnt;
    logic          settle_done;
    logic          line_ok;
    sdq_src_e      det_src;

    sdq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (level_raw),
        .q_o   (level_s)
    );

    sdq_settle_timer #(.LIMIT(SETTLE_CYCLES), .CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (level_s),
        .cnt_o   (settle_cnt),
        .done_o  (settle_done)
    );

    // Line qualification also needs the current level, so a drop is seen at once.
    assign line_ok = level_s & settle_done;

    sdq_out_sel u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_ok_i (line_ok),
        .loop_i    (loopback),
        .det_o     (sig_det),
        .src_o     (det_src)
    );
endmodule

// File: rtl/sdq_chk.sv
// Module: assertion checker for sigdet_qualifier, attached by bind.
// Assumes: it sees the top's ports and internal nets by name.
module sdq_chk #(
    parameter int unsigned SETTLE_CYCLES = 2,
    parameter int unsigned CW            = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          loopback,
    input logic          sig_det,
    input logic          level_s,
    input logic [CW-1:0] settle_cnt
);
    localparam logic [CW-1:0] LIM = CW'(SETTLE_CYCLES);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!sig_det && settle_cnt == '0));

    // R7
    loop_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (loopback && $past(rst_n)) |-> sig_det);

    // R5
    drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_s && !loopback) |-> !sig_det);

    // R6
    drop_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !level_s |=> settle_cnt == '0);

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        settle_cnt <= LIM);

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level_s && settle_cnt != LIM) |=> (settle_cnt == $past(settle_cnt) + 1'b1) || !rst_n);

    // R3
    early_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_det && !loopback) |-> settle_cnt == LIM);
endmodule

bind sigdet_qualifier sdq_chk #(
    .SETTLE_CYCLES(SETTLE_CYCLES),
    .CW(CW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .loopback   (loopback),
    .sig_det    (sig_det),
    .level_s    (level_s),
    .settle_cnt (settle_cnt)
);

// File: tb/sim_sigdet_qualifier.sv
// Bench: sweeps pulse and gap lengths around the settling limit, with and
// without loopback, and compares sig_det every cycle against a model
// derived from the requirement timing.
module sim_sigdet_qualifier;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic level_raw = 1'b0;
    logic loopback = 1'b0;
    logic sig_det;

    int checks = 0;
    int fails  = 0;

    int  run_now  = 0;   // consecutive high samples ending at the last edge
    int  run_prev = 0;   // same, ending at the edge before
    bit  live_m   = 0;   // reset was released at the last edge

    always #(CLK_PERIOD/2) clk = ~clk;

    sigdet_qualifier #(.SETTLE_CYCLES(LIMIT), .SYNC_STAGES(2)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .level_raw (level_raw),
        .loopback  (loopback),
        .sig_det   (sig_det)
    );

    // Model: a sample must survive the sync (R2). It is then counted for
    // LIMIT edges (R3), so LIMIT+1 high samples ending at the previous edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            run_now = 0; run_prev = 0; live_m = 0;
        end else begin
            run_prev = run_now;
            run_now  = level_raw ? run_now + 1 : 0;
            live_m   = 1;
        end
    end

    task automatic check(input string tag);
        logic exp;
        exp = live_m && (loopback || (run_prev >= LIMIT + 1));
        checks++;
        if (sig_det !== exp) begin
            fails++;
            $display("FAIL %s: sig_det=%b expected=%b (run=%0d lb=%b)",
                     tag, sig_det, exp, run_prev, loopback);
        end
    endtask

    task automatic step(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(tag);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset with line high and loopback set
        level_raw = 1'b1; loopback = 1'b1;
        step(4, "R1 reset");
        @(negedge clk); rst_n = 1'b1; level_raw = 1'b0; loopback = 1'b0;
        step(3, "R1 after reset");

        // R2 R3 R5 R6: sweep pulse lengths around the limit, several gaps
        for (int g = 1; g <= 3; g++) begin
            for (int h = 1; h <= LIMIT + 4; h++) begin
                level_raw = 1'b1;
                step(h, "R3 R6 pulse");
                level_raw = 1'b0;
                step(g, "R5 R2 drop");
            end
        end
        step(3, "R5 idle");

        // R4 R9: long steady signal, far beyond the limit
        level_raw = 1'b1;
        step(LIMIT * 8, "R4 R9 steady");
        level_raw = 1'b0;
        step(3, "R5 loss");

        // R7 R8: loopback over idle, mid-count and qualified line
        for (int l = 0; l <= LIMIT + 3; l++) begin
            loopback = 1'b1;
            step(2, "R7 loop idle");
            level_raw = 1'b1;
            step(l, "R7 loop count");
            loopback = 1'b0;
            step(LIMIT + 3, "R8 release");
            level_raw = 1'b0;
            step(3, "R8 drop");
        end

        // R7: loopback toggled while the line drops
        level_raw = 1'b1;
        step(LIMIT + 3, "R3 qualify");
        loopback = 1'b1; level_raw = 1'b0;
        step(4, "R7 drop in loop");
        loopback = 1'b0;
        step(2, "R8 after loop");

        // R1: reset in mid-flight clears a qualified flag
        level_raw = 1'b1;
        step(LIMIT + 3, "R3 qualify2");
        rst_n = 1'b0;
        step(2, "R1 mid reset");
        rst_n = 1'b1;
        step(LIMIT + 4, "R1 R3 restart");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule